// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block gates a small set of power domains on and off under software control through an APB register port. Software marks the domains it wants to act on in a turn-on select register or a turn-off select register. It then arms the change by writing a short byte sequence into a single command register. A parser checks the bytes in order. Only a correct sequence starts the change. A wrong byte is flagged as a software failure and discards the partial sequence.

An accepted request hands a set of domains to a switch sequencer. The sequencer steps through them one at a time, in ascending bit order. Each domain waits a fixed, parameterised number of clock cycles before its enable output flips. The current-state register and the per-domain enable outputs always agree. Completion, malformed sequences and requests that arrive while a change is in progress are recorded as status bits. The status bits are write-one-to-clear, and each can be masked from the interrupt output.

The two lowest domains hold always-on logic and cannot be switched off. The power-switch delay is set so that a full seven-domain change finishes inside the system's 100 µs budget.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset: the current-state register (offset 0x80) and `dom_en` read 0x03, so only domains 0 and 1 are on. The interrupt mask (0x48) reads 0x1FF. Interrupt status (0x8C) and event status (0x88) read 0. `irq` is low.
- R2: The turn-on select register (0x0C) and turn-off select register (0x10) keep and read back the low 7 bits written to them. The interrupt mask keeps and reads back the low 9 bits.
- R3: Writing 0xFF, then 0x05, then 0x50 to the command register (0x44) turns on every domain whose bit is 1 in the turn-on select register. Domains whose bit is 0 are left as they are. Once the change completes, their state bits read 1.
- R4: Writing 0xFF, then 0x0A, then 0xA0 to the command register turns off every domain whose bit is 1 in the turn-off select register, except domains 0 and 1. Those two stay on at all times.
- R5: After 0xFF, any byte other than the expected next byte does three things: it sets bit 2 of interrupt status and of event status, it changes no domain, and it returns the parser to waiting for 0xFF. A later lone high byte therefore has no effect. A 0xFF written at any point restarts the sequence without flagging a failure.
- R6: Command bytes written while the parser waits for 0xFF change no domain and set no status bit.
- R7: The domains in one request switch one at a time, in ascending bit order, each SWITCH_CYCLES clock cycles after the previous one. The first switches SWITCH_CYCLES cycles after the clock edge that accepts the final command byte. Bit 0 of interrupt status and event status (sequence done) is set one cycle after the last domain switches.
- R8: A request that would change no domain sets the sequence-done bit on the clock edge after the one that accepts it, and no domain changes. This happens when the select register is zero, or when every selected domain is already in the requested state.
- R9: A completed command sequence that arrives while a change is still in progress is dropped, and it sets bit 3 of interrupt status and event status.
- R10: Writing 1 to a bit of interrupt status or event status clears that bit only. Writing 0 leaves the bit unchanged, and the two registers are cleared independently.
- R11: `irq` is high exactly when some interrupt-status bit is set while the matching mask bit is 0. A mask bit of 1 suppresses that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB and block clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| dom_en | output | NUM_DOM | Per-domain power enable, 1 = powered |
| irq | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
The assertions assume well-formed APB traffic: every access has a setup cycle with `psel` high and `penable` low, then exactly one access cycle, and transfers never overlap. They also assume SWITCH_CYCLES is at least 1. Under those assumptions the enables change only while the sequencer is busy, at most one enable changes per cycle, and each done, failure or reject event lands in its status bit on the next edge. The bench issues every access through one two-phase task that runs to completion before the next begins. The single exception is a deliberate overlap of a second command sequence with a change still in progress.

// File: rtl/pdsc_pkg.sv
package pdsc_pkg;

    // Command bytes understood by the unlock parser
    localparam logic [7:0] CMD_RESET  = 8'hFF;
    localparam logic [7:0] CMD_ON_LO  = 8'h05;
    localparam logic [7:0] CMD_ON_HI  = 8'h50;
    localparam logic [7:0] CMD_OFF_LO = 8'h0A;
    localparam logic [7:0] CMD_OFF_HI = 8'hA0;

    // Register byte offsets (software-visible map)
    localparam logic [7:0] OFS_ON_SEL  = 8'h0C;
    localparam logic [7:0] OFS_OFF_SEL = 8'h10;
    localparam logic [7:0] OFS_CMD     = 8'h44;
    localparam logic [7:0] OFS_IMASK   = 8'h48;
    localparam logic [7:0] OFS_PSTATE  = 8'h80;
    localparam logic [7:0] OFS_EVENT   = 8'h88;
    localparam logic [7:0] OFS_ISTAT   = 8'h8C;

    // Status vector layout
    localparam int IRQ_W        = 9;
    localparam int IRQ_DONE     = 0;
    localparam int IRQ_BAD_SEQ  = 2;
    localparam int IRQ_BUSY_REJ = 3;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_ARMED,
        PS_ON_LO,
        PS_OFF_LO
    } parse_st_e;

endpackage

// File: rtl/pdsc_cmd_parser.sv
module pdsc_cmd_parser
    import pdsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    output logic       fire_on,
    output logic       fire_off,
    output logic       seq_fail
);

    typedef struct packed {
        parse_st_e st;
    } parse_regs_t;

    parse_regs_t q, d;

    always_comb begin
        d        = q;
        fire_on  = 1'b0;
        fire_off = 1'b0;
        seq_fail = 1'b0;
        if (wr_en) begin
            if (wr_byte == CMD_RESET) begin
                // restart from any state, never a failure
                d.st = PS_ARMED;
            end else begin
                case (q.st)
                    PS_ARMED: begin
                        if (wr_byte == CMD_ON_LO) begin
                            d.st = PS_ON_LO;
                        end else if (wr_byte == CMD_OFF_LO) begin
                            d.st = PS_OFF_LO;
                        end else begin
                            d.st     = PS_IDLE;
                            seq_fail = 1'b1;
                        end
                    end
                    PS_ON_LO: begin
                        d.st = PS_IDLE;
                        if (wr_byte == CMD_ON_HI) fire_on  = 1'b1;
                        else                      seq_fail = 1'b1;
                    end
                    PS_OFF_LO: begin
                        d.st = PS_IDLE;
                        if (wr_byte == CMD_OFF_HI) fire_off = 1'b1;
                        else                       seq_fail = 1'b1;
                    end
                    default: begin
                        // waiting for the reset byte: stray bytes are dropped
                        d.st = PS_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: PS_IDLE};
        else        q <= d;
    end

endmodule

// File: rtl/pdsc_switch_seq.sv
module pdsc_switch_seq #(
    parameter int                 NUM_DOM       = 7,
    parameter int                 SWITCH_CYCLES = 16,
    parameter logic [NUM_DOM-1:0] KEEP_ON       = 7'b0000011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_on,
    input  logic               start_off,
    input  logic [NUM_DOM-1:0] on_sel,
    input  logic [NUM_DOM-1:0] off_sel,
    output logic [NUM_DOM-1:0] pwr_state,
    output logic               busy,
    output logic               done,
    output logic               reject
);

    localparam int CNT_W = $clog2(SWITCH_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SWITCH_CYCLES - 1);

    typedef struct packed {
        logic [NUM_DOM-1:0] pend;
        logic [NUM_DOM-1:0] state;
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        logic               done;
    } seq_regs_t;

    seq_regs_t q, d;
    logic [NUM_DOM-1:0] req;
    logic [NUM_DOM-1:0] low;
    logic               start;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        start  = start_on | start_off;
        req    = '0;
        if (start_on)       req = on_sel & ~q.state;
        else if (start_off) req = off_sel & ~KEEP_ON & q.state;
        // lowest pending domain goes first
        low    = q.pend & (~q.pend + NUM_DOM'(1));
        reject = start & q.busy;

        if (!q.busy) begin
            if (start) begin
                if (req == '0) begin
                    d.done = 1'b1;
                end else begin
                    d.pend = req;
                    d.busy = 1'b1;
                    d.cnt  = CNT_LOAD;
                end
            end
        end else if (q.cnt == '0) begin
            d.state = q.state ^ low;
            d.pend  = q.pend & ~low;
            if (d.pend == '0) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = CNT_LOAD;
            end
        end else begin
            d.cnt = q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{pend: '0, state: KEEP_ON, busy: 1'b0, cnt: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign pwr_state = q.state;
    assign busy      = q.busy;
    assign done      = q.done;

endmodule

// File: rtl/pdsc_regs.sv
module pdsc_regs
    import pdsc_pkg::*;
#(
    parameter int NUM_DOM = 7,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    input  logic [NUM_DOM-1:0] pwr_state,
    input  logic               ev_done,
    input  logic               ev_fail,
    input  logic               ev_reject,
    output logic [NUM_DOM-1:0] on_sel,
    output logic [NUM_DOM-1:0] off_sel,
    output logic               cmd_wr,
    output logic [7:0]         cmd_byte,
    output logic [IRQ_W-1:0]   int_st,
    output logic               irq
);

    typedef struct packed {
        logic [NUM_DOM-1:0] on_sel;
        logic [NUM_DOM-1:0] off_sel;
        logic [IRQ_W-1:0]   mask;
        logic [IRQ_W-1:0]   int_st;
        logic [IRQ_W-1:0]   evt_st;
    } reg_file_t;

    reg_file_t        q, d;
    logic             wr;
    logic [IRQ_W-1:0] ev_set;
    logic             unused_wdata;

    assign unused_wdata = ^pwdata[31:IRQ_W];

    always_comb begin
        d      = q;
        wr     = psel & penable & pwrite;
        ev_set = '0;
        ev_set[IRQ_DONE]     = ev_done;
        ev_set[IRQ_BAD_SEQ]  = ev_fail;
        ev_set[IRQ_BUSY_REJ] = ev_reject;
        cmd_wr   = wr && (paddr == ADDR_W'(OFS_CMD));
        cmd_byte = pwdata[7:0];

        if (wr) begin
            case (paddr)
                ADDR_W'(OFS_ON_SEL):  d.on_sel  = pwdata[NUM_DOM-1:0];
                ADDR_W'(OFS_OFF_SEL): d.off_sel = pwdata[NUM_DOM-1:0];
                ADDR_W'(OFS_IMASK):   d.mask    = pwdata[IRQ_W-1:0];
                ADDR_W'(OFS_ISTAT):   d.int_st  = q.int_st & ~pwdata[IRQ_W-1:0];
                ADDR_W'(OFS_EVENT):   d.evt_st  = q.evt_st & ~pwdata[IRQ_W-1:0];
                default: ;
            endcase
        end
        // a new event wins over a clear in the same cycle
        d.int_st = d.int_st | ev_set;
        d.evt_st = d.evt_st | ev_set;
    end

    always_comb begin
        prdata = '0;
        case (paddr)
            ADDR_W'(OFS_ON_SEL):  prdata[NUM_DOM-1:0] = q.on_sel;
            ADDR_W'(OFS_OFF_SEL): prdata[NUM_DOM-1:0] = q.off_sel;
            ADDR_W'(OFS_IMASK):   prdata[IRQ_W-1:0]   = q.mask;
            ADDR_W'(OFS_PSTATE):  prdata[NUM_DOM-1:0] = pwr_state;
            ADDR_W'(OFS_EVENT):   prdata[IRQ_W-1:0]   = q.evt_st;
            ADDR_W'(OFS_ISTAT):   prdata[IRQ_W-1:0]   = q.int_st;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{on_sel: '0, off_sel: '0, mask: '1, int_st: '0, evt_st: '0};
        end else begin
            q <= d;
        end
    end

    assign on_sel  = q.on_sel;
    assign off_sel = q.off_sel;
    assign int_st  = q.int_st;
    assign irq     = |(q.int_st & ~q.mask);

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
    import pdsc_pkg::*;
#(
    parameter int NUM_DOM       = 7,
    parameter int ADDR_W        = 8,
    parameter int SWITCH_CYCLES = 16
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic               pready,
    output logic [NUM_DOM-1:0] dom_en,
    output logic               irq
);

    localparam logic [NUM_DOM-1:0] KEEP_ON = NUM_DOM'(3);

    logic               cmd_wr;
    logic [7:0]         cmd_byte;
    logic               fire_on;
    logic               fire_off;
    logic               seq_fail;
    logic [NUM_DOM-1:0] on_sel;
    logic [NUM_DOM-1:0] off_sel;
    logic [NUM_DOM-1:0] pwr_state;
    logic               seq_busy;
    logic               seq_done;
    logic               seq_reject;
    logic [IRQ_W-1:0]   int_st;

    pdsc_regs #(
        .NUM_DOM (NUM_DOM),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (pclk),
        .rst_n     (presetn),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .pwr_state (pwr_state),
        .ev_done   (seq_done),
        .ev_fail   (seq_fail),
        .ev_reject (seq_reject),
        .on_sel    (on_sel),
        .off_sel   (off_sel),
        .cmd_wr    (cmd_wr),
        .cmd_byte  (cmd_byte),
        .int_st    (int_st),
        .irq       (irq)
    );

    pdsc_cmd_parser u_parser (
        .clk      (pclk),
        .rst_n    (presetn),
        .wr_en    (cmd_wr),
        .wr_byte  (cmd_byte),
        .fire_on  (fire_on),
        .fire_off (fire_off),
        .seq_fail (seq_fail)
    );

    pdsc_switch_seq #(
        .NUM_DOM       (NUM_DOM),
        .SWITCH_CYCLES (SWITCH_CYCLES),
        .KEEP_ON       (KEEP_ON)
    ) u_seq (
        .clk       (pclk),
        .rst_n     (presetn),
        .start_on  (fire_on),
        .start_off (fire_off),
        .on_sel    (on_sel),
        .off_sel   (off_sel),
        .pwr_state (pwr_state),
        .busy      (seq_busy),
        .done      (seq_done),
        .reject    (seq_reject)
    );

    assign dom_en = pwr_state;
    assign pready = 1'b1;

endmodule

// File: rtl/pdsc_checker.sv
module pdsc_checker #(
    parameter int NUM_DOM = 7,
    parameter int IRQ_W   = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_DOM-1:0] dom_en,
    input logic               busy,
    input logic               done,
    input logic               fail,
    input logic               reject,
    input logic [IRQ_W-1:0]   int_st
);

    // R4
    keep_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dom_en[1:0] == 2'b11);

    // R7
    one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dom_en ^ $past(dom_en)) <= 1);

    // R7
    change_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dom_en) |-> $past(busy));

    // R8
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> int_st[0]);

    // R5
    bad_seq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> int_st[2]);

    // R9
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> int_st[3]);

endmodule

bind pwr_domain_seq pdsc_checker #(
    .NUM_DOM (NUM_DOM),
    .IRQ_W   (pdsc_pkg::IRQ_W)
) u_chk (
    .clk    (pclk),
    .rst_n  (presetn),
    .dom_en (dom_en),
    .busy   (seq_busy),
    .done   (seq_done),
    .fail   (seq_fail),
    .reject (seq_reject),
    .int_st (int_st)
);

// File: tb/pwr_domain_seq_test.sv
`timescale 1ns/1ps
module pwr_domain_seq_test;

    localparam int ND   = 7;
    localparam int SC   = 4;
    localparam int SETL = ND * SC + 4;

    localparam logic [7:0] A_ON  = 8'h0C;
    localparam logic [7:0] A_OFF = 8'h10;
    localparam logic [7:0] A_CMD = 8'h44;
    localparam logic [7:0] A_MSK = 8'h48;
    localparam logic [7:0] A_PST = 8'h80;
    localparam logic [7:0] A_EVT = 8'h88;
    localparam logic [7:0] A_IST = 8'h8C;

    logic          pclk = 1'b0;
    logic          presetn = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [7:0]    paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready;
    logic [ND-1:0] dom_en;
    logic          irq;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    logic finished = 1'b0;
    logic [ND-1:0] exp_st;
    logic [31:0]   rd;

    always #4 pclk = ~pclk;

    pwr_domain_seq #(.NUM_DOM(ND), .ADDR_W(8), .SWITCH_CYCLES(SC)) uut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .dom_en(dom_en), .irq(irq)
    );

    always @(posedge pclk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: run did not finish, cycles %0d expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = v;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1 v = prdata;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic cmd_seq(input logic turn_on);
        apb_wr(A_CMD, 32'hFF);
        apb_wr(A_CMD, turn_on ? 32'h05 : 32'h0A);
        apb_wr(A_CMD, turn_on ? 32'h50 : 32'hA0);
    endtask

    task automatic settle();
        repeat (SETL) @(negedge pclk);
    endtask

    task automatic clr_all();
        apb_wr(A_IST, 32'h1FF);
        apb_wr(A_EVT, 32'h1FF);
    endtask

    initial begin
        repeat (4) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);

        // R1 reset state
        apb_rd(A_PST, rd); chk("R1 state", rd, 32'h03);
        chk("R1 dom_en", {25'd0, dom_en}, 32'h03);
        apb_rd(A_MSK, rd); chk("R1 mask", rd, 32'h1FF);
        apb_rd(A_IST, rd); chk("R1 istat", rd, 32'h0);
        apb_rd(A_EVT, rd); chk("R1 event", rd, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        exp_st = 7'h03;

        // R2 register read-back
        apb_wr(A_ON, 32'hFFFF_FF55); apb_rd(A_ON, rd); chk("R2 on_sel", rd, 32'h55);
        apb_wr(A_OFF, 32'h2A);       apb_rd(A_OFF, rd); chk("R2 off_sel", rd, 32'h2A);
        apb_wr(A_MSK, 32'hFFF0);     apb_rd(A_MSK, rd); chk("R2 mask", rd, 32'h1F0);
        apb_wr(A_MSK, 32'h1FF);

        // R7 serial timing: domains 2 and 4
        apb_wr(A_ON, 32'h14);
        cmd_seq(1'b1);
        for (int k = 1; k <= 2 * SC + 1; k++) begin
            @(negedge pclk);
            if (k == SC - 1)     chk("R7 before first", {25'd0, dom_en}, 32'h03);
            if (k == SC)         chk("R7 first switch", {25'd0, dom_en}, 32'h07);
            if (k == 2 * SC - 1) chk("R7 before second", {25'd0, dom_en}, 32'h07);
            if (k == 2 * SC)     chk("R7 second switch", {25'd0, dom_en}, 32'h17);
        end
        apb_rd(A_IST, rd); chk("R7 done bit", rd, 32'h1);
        exp_st = 7'h17;
        clr_all();

        // R3 / R4 sweep over all turn-on selections and derived turn-off ones
        for (int m = 0; m < 128; m++) begin
            logic [ND-1:0] p;
            p = ND'((m * 5 + 3) & 127);
            apb_wr(A_ON, 32'(m));
            cmd_seq(1'b1);
            settle();
            exp_st = exp_st | ND'(m);
            apb_rd(A_PST, rd); chk("R3 on sweep state", rd, {25'd0, exp_st});
            apb_rd(A_IST, rd); chk("R3 on sweep done", rd, 32'h1);
            clr_all();
            apb_wr(A_OFF, {25'd0, p});
            cmd_seq(1'b0);
            settle();
            exp_st = exp_st & ~(p & 7'h7C);
            chk("R4 off sweep dom_en", {25'd0, dom_en}, {25'd0, exp_st});
            apb_rd(A_IST, rd); chk("R4 off sweep done", rd, 32'h1);
            clr_all();
        end

        // R8 empty requests: selected domains already on, and zero selection
        apb_wr(A_ON, {25'd0, exp_st});
        cmd_seq(1'b1);
        apb_rd(A_IST, rd); chk("R8 already-on done", rd, 32'h1);
        chk("R8 already-on state", {25'd0, dom_en}, {25'd0, exp_st});
        clr_all();
        apb_wr(A_OFF, 32'h0);
        cmd_seq(1'b0);
        apb_rd(A_IST, rd); chk("R8 zero select done", rd, 32'h1);
        chk("R8 zero select state", {25'd0, dom_en}, {25'd0, exp_st});
        clr_all();

        // bring everything down to the always-on pair
        apb_wr(A_OFF, 32'h7F);
        cmd_seq(1'b0);
        settle();
        exp_st = 7'h03;
        chk("R4 keep-on pair", {25'd0, dom_en}, 32'h03);
        clr_all();

        // R5 wrong second and third bytes
        apb_wr(A_ON, 32'h7C);
        apb_wr(A_CMD, 32'hFF); apb_wr(A_CMD, 32'h05); apb_wr(A_CMD, 32'hA0);
        apb_rd(A_IST, rd); chk("R5 bad high istat", rd, 32'h4);
        apb_rd(A_EVT, rd); chk("R5 bad high event", rd, 32'h4);
        apb_wr(A_CMD, 32'h50);
        settle();
        chk("R5 lone high ignored", {25'd0, dom_en}, 32'h03);
        clr_all();
        apb_wr(A_CMD, 32'hFF); apb_wr(A_CMD, 32'h33);
        apb_rd(A_IST, rd); chk("R5 bad low istat", rd, 32'h4);
        clr_all();
        // R5 restart with 0xFF mid-sequence is not a failure
        apb_wr(A_CMD, 32'hFF); apb_wr(A_CMD, 32'h05); cmd_seq(1'b1);
        settle();
        apb_rd(A_IST, rd); chk("R5 restart istat", rd, 32'h1);
        chk("R5 restart state", {25'd0, dom_en}, 32'h7F);
        exp_st = 7'h7F;
        clr_all();

        // R6 bytes without the reset byte
        apb_wr(A_OFF, 32'h7C);
        apb_wr(A_CMD, 32'h0A); apb_wr(A_CMD, 32'hA0);
        settle();
        apb_rd(A_IST, rd); chk("R6 no flag", rd, 32'h0);
        chk("R6 no change", {25'd0, dom_en}, 32'h7F);

        // R9 sequence while busy: bring down, then on + overlapping off
        cmd_seq(1'b0);
        settle();
        clr_all();
        apb_wr(A_ON, 32'h7C);
        cmd_seq(1'b1);
        cmd_seq(1'b0);
        settle();
        chk("R9 off dropped", {25'd0, dom_en}, 32'h7F);
        apb_rd(A_IST, rd); chk("R9 reject bit", rd, 32'h9);

        // R10 write-one-to-clear
        apb_wr(A_IST, 32'h0); apb_rd(A_IST, rd); chk("R10 zero write", rd, 32'h9);
        apb_wr(A_IST, 32'h1); apb_rd(A_IST, rd); chk("R10 clear bit0", rd, 32'h8);
        apb_rd(A_EVT, rd); chk("R10 event untouched", rd, 32'h9);
        apb_wr(A_EVT, 32'h8); apb_rd(A_EVT, rd); chk("R10 event clear", rd, 32'h1);

        // R11 interrupt masking
        chk("R11 all masked", {31'd0, irq}, 32'h0);
        apb_wr(A_MSK, 32'h1F7); chk("R11 bit3 unmasked", {31'd0, irq}, 32'h1);
        apb_wr(A_MSK, 32'h1FF); chk("R11 remasked", {31'd0, irq}, 32'h0);
        apb_wr(A_MSK, 32'h000); chk("R11 none masked", {31'd0, irq}, 32'h1);
        apb_wr(A_IST, 32'h8);   chk("R11 cleared", {31'd0, irq}, 32'h0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule